// File: doc/BRIEF.md
# Event Identifier Allocation Manager

This block is the central bookkeeper for event identifiers in an event-assembly system. A fixed pool of identifiers sits in a free list. Builder units ask the manager for events and receive identifiers that are now theirs. When a builder has gathered every fragment of an event, it sends a clear message, and the identifier goes back into the pool. At any moment, every event that is in flight holds an identifier that no other in-flight event holds.

Requests arrive on a valid/ready interface. A request is either an allocate or a clear. It names the builder and carries a count, so one message can ask for, or release, up to `MAX_OPS` identifiers. The manager handles the operations one after another and then gives a single response. For an allocate, the response lists the granted identifiers. For a clear, it gives the number released. Partial grants are normal. A grant stops when the pool runs dry or when the builder reaches its cap on outstanding events. A clear for an identifier that the requester does not own changes nothing and raises an error bit in the response.

Top module: `eid_alloc_mgr`

## Requirements
- R1: For `NUM_IDS` cycles after reset is released, `req_ready` stays low while the pool is filled with every identifier, and `rsp_valid` is low. The first identifiers handed out are 0, 1, 2, ... in ascending order.
- R2: An allocate request (`req_op`=0) with count n returns k identifiers, with k no larger than n. `rsp_count`=k, and slot i is at `rsp_ids[i*ID_W +: ID_W]` for i<k. Slots at and above k read zero.
- R3: The pool is first-in first-out. A released identifier is handed out again only after every identifier that was freed before it.
- R4: When the pool holds fewer identifiers than requested, the manager grants all it has. An empty pool grants 0.
- R5: A builder never holds more than `LIMIT` identifiers. Allocation for that builder stops at the cap, and `rsp_count` shows the shortfall.
- R6: A clear request (`req_op`=1) takes its identifiers from slots 0..n-1 of `req_ids`. Each identifier owned by the requester returns to the pool and lowers that builder's outstanding count. `rsp_count` is the number released.
- R7: A clear entry for an identifier that is free, or that another builder owns, is ignored. The identifier does not enter the pool, its owner is unchanged, and `rsp_err`=1. The same applies to a repeated entry within one message.
- R8: A count of 0 gives a response with `rsp_count`=0 and changes nothing. A count above `MAX_OPS` is treated as `MAX_OPS`.
- R9: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response. Each accepted request produces exactly one `rsp_valid` pulse, one cycle long, and `rsp_err` is high only during that pulse.
- R10: The pool never takes a push while it is full and never gives a pop while it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Manager idle and able to take a request |
| req_op | input | 1 | 0 = allocate, 1 = clear |
| req_bu | input | BU_W | Requesting builder index |
| req_count | input | CNT_W | Number of operations bundled in the request |
| req_ids | input | MAX_OPS*ID_W | Identifiers to clear, slot i at bits [i*ID_W +: ID_W] |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_count | output | CNT_W | Identifiers granted or released |
| rsp_ids | output | MAX_OPS*ID_W | Granted identifiers, packed from slot 0 |
| rsp_err | output | 1 | At least one clear entry was not owned by the requester |

## Verification
The first test is a small allocate on a fresh pool, which confirms ascending fill order. An oversized allocate then hits both the count clamp and the per-builder cap in one message. After that, clears return identifiers out of order and a second builder drains the pool. This shows whether reuse follows release order and whether a partial grant and an empty-pool grant are reported exactly. The clears of a foreign identifier, of a free identifier, and of a duplicated identifier within one bundle separate proper ownership checks from checks that only look at free/busy state. A reference model tracks the pool, the owners and the outstanding counts, and every response is compared against it.

// File: rtl/eid_pkg.sv
package eid_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_ARD,
    ST_AWR,
    ST_CLR,
    ST_DONE
  } mgr_state_t;

  localparam logic OP_ALLOC = 1'b0;
  localparam logic OP_CLEAR = 1'b1;
endpackage

// File: rtl/eid_free_fifo.sv
module eid_free_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_id,
  input  logic                       pop,
  output logic [W-1:0]               pop_id,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  // storage with registered read port, no reset on the array
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_id;
    if (pop)  pop_id      <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      level <= level + LVL_W'(1);
      else if (pop && !push) level <= level - LVL_W'(1);
    end
  end

  assign empty = (level == '0);
endmodule

// File: rtl/eid_owner_table.sv
module eid_owner_table #(
  parameter int NUM_IDS = 32,
  parameter int NUM_BU  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       set_en,
  input  logic [$clog2(NUM_IDS)-1:0] set_id,
  input  logic [$clog2(NUM_BU)-1:0]  set_bu,
  input  logic                       clr_en,
  input  logic [$clog2(NUM_IDS)-1:0] clr_id,
  input  logic [$clog2(NUM_IDS)-1:0] look_id,
  input  logic [$clog2(NUM_BU)-1:0]  look_bu,
  output logic                       look_hit
);
  localparam int ID_W = $clog2(NUM_IDS);
  localparam int BU_W = $clog2(NUM_BU);

  logic [NUM_IDS-1:0] busy_vec;
  logic [BU_W-1:0]    who_arr [NUM_IDS];

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_entry
    logic            busy_r;
    logic [BU_W-1:0] who_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        busy_r <= 1'b0;
        who_r  <= '0;
      end else if (set_en && set_id == ID_W'(g)) begin
        busy_r <= 1'b1;
        who_r  <= set_bu;
      end else if (clr_en && clr_id == ID_W'(g)) begin
        busy_r <= 1'b0;
      end
    end
    assign busy_vec[g] = busy_r;
    assign who_arr[g]  = who_r;
  end

  assign look_hit = busy_vec[look_id] && (who_arr[look_id] == look_bu);
endmodule

// File: rtl/eid_quota.sv
module eid_quota #(
  parameter int NUM_BU = 4,
  parameter int LIMIT  = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [$clog2(NUM_BU)-1:0] sel_bu,
  input  logic                      inc_en,
  input  logic                      dec_en,
  output logic                      at_limit
);
  localparam int BU_W = $clog2(NUM_BU);
  localparam int Q_W  = $clog2(LIMIT+1);

  logic [NUM_BU-1:0] full_vec;

  for (genvar b = 0; b < NUM_BU; b++) begin : g_bu
    logic [Q_W-1:0] cnt_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_r <= '0;
      end else if (sel_bu == BU_W'(b)) begin
        if (inc_en && !dec_en)      cnt_r <= cnt_r + Q_W'(1);
        else if (dec_en && !inc_en) cnt_r <= cnt_r - Q_W'(1);
      end
    end
    assign full_vec[b] = (cnt_r == Q_W'(LIMIT));
  end

  assign at_limit = full_vec[sel_bu];
endmodule

// File: rtl/eid_alloc_mgr.sv
module eid_alloc_mgr #(
  parameter int NUM_BU  = 4,
  parameter int NUM_IDS = 32,
  parameter int MAX_OPS = 16,
  parameter int LIMIT   = 12,
  localparam int ID_W   = $clog2(NUM_IDS),
  localparam int BU_W   = $clog2(NUM_BU),
  localparam int CNT_W  = $clog2(MAX_OPS+1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_op,
  input  logic [BU_W-1:0]         req_bu,
  input  logic [CNT_W-1:0]        req_count,
  input  logic [MAX_OPS*ID_W-1:0] req_ids,
  output logic                    rsp_valid,
  output logic [CNT_W-1:0]        rsp_count,
  output logic [MAX_OPS*ID_W-1:0] rsp_ids,
  output logic                    rsp_err
);
  import eid_pkg::*;
  localparam int LVL_W = $clog2(NUM_IDS+1);

  mgr_state_t              state;
  logic                    op_q;
  logic [BU_W-1:0]         bu_q;
  logic [MAX_OPS*ID_W-1:0] ids_q, slots_q;
  logic [CNT_W-1:0]        n_q, idx_q, got_q, n_clamp, idx_nx;
  logic                    err_q;
  logic [ID_W-1:0]         init_q, cur_id, pop_id;
  logic [LVL_W-1:0]        fifo_level;
  logic                    fifo_empty, fifo_push, fifo_pop, own_hit;
  logic                    quota_full, quota_inc, quota_dec, last_op;

  assign n_clamp   = (req_count > CNT_W'(MAX_OPS)) ? CNT_W'(MAX_OPS) : req_count;
  assign cur_id    = ids_q[int'(idx_q)*ID_W +: ID_W];
  assign idx_nx    = idx_q + CNT_W'(1);
  assign last_op   = (idx_nx == n_q);
  assign fifo_push = (state == ST_INIT) || (state == ST_CLR && own_hit);
  assign fifo_pop  = (state == ST_ARD) && !fifo_empty && !quota_full;
  assign quota_inc = (state == ST_AWR);
  assign quota_dec = (state == ST_CLR) && own_hit;
  assign req_ready = (state == ST_IDLE);

  eid_free_fifo #(.DEPTH(NUM_IDS), .W(ID_W)) u_pool (
    .clk(clk), .rst(rst),
    .push(fifo_push), .push_id((state == ST_INIT) ? init_q : cur_id),
    .pop(fifo_pop), .pop_id(pop_id),
    .level(fifo_level), .empty(fifo_empty)
  );

  eid_owner_table #(.NUM_IDS(NUM_IDS), .NUM_BU(NUM_BU)) u_owner (
    .clk(clk), .rst(rst),
    .set_en(state == ST_AWR), .set_id(pop_id), .set_bu(bu_q),
    .clr_en(quota_dec), .clr_id(cur_id),
    .look_id(cur_id), .look_bu(bu_q), .look_hit(own_hit)
  );

  eid_quota #(.NUM_BU(NUM_BU), .LIMIT(LIMIT)) u_quota (
    .clk(clk), .rst(rst), .sel_bu(bu_q),
    .inc_en(quota_inc), .dec_en(quota_dec), .at_limit(quota_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_INIT;
      init_q    <= '0;
      op_q      <= OP_ALLOC;
      bu_q      <= '0;
      ids_q     <= '0;
      slots_q   <= '0;
      n_q       <= '0;
      idx_q     <= '0;
      got_q     <= '0;
      err_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_count <= '0;
      rsp_ids   <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_count <= '0;
      rsp_err   <= 1'b0;
      unique case (state)
        ST_INIT: begin
          init_q <= init_q + ID_W'(1);
          if (init_q == ID_W'(NUM_IDS-1)) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (req_valid) begin
            op_q    <= req_op;
            bu_q    <= req_bu;
            ids_q   <= req_ids;
            n_q     <= n_clamp;
            idx_q   <= '0;
            got_q   <= '0;
            err_q   <= 1'b0;
            slots_q <= '0;
            if (n_clamp == '0)          state <= ST_DONE;
            else if (req_op == OP_CLEAR) state <= ST_CLR;
            else                         state <= ST_ARD;
          end
        end
        ST_ARD: begin
          state <= fifo_pop ? ST_AWR : ST_DONE;
        end
        ST_AWR: begin
          slots_q[int'(got_q)*ID_W +: ID_W] <= pop_id;
          got_q <= got_q + CNT_W'(1);
          idx_q <= idx_nx;
          state <= last_op ? ST_DONE : ST_ARD;
        end
        ST_CLR: begin
          if (own_hit) got_q <= got_q + CNT_W'(1);
          else         err_q <= 1'b1;
          idx_q <= idx_nx;
          if (last_op) state <= ST_DONE;
        end
        ST_DONE: begin
          rsp_valid <= 1'b1;
          rsp_count <= got_q;
          rsp_ids   <= slots_q;
          rsp_err   <= err_q;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eid_alloc_mgr_chk.sv
module eid_alloc_mgr_chk #(
  parameter int NUM_IDS = 32,
  parameter int MAX_OPS = 16,
  parameter int LVL_W   = 6,
  parameter int CNT_W   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_push,
  input logic             fifo_pop,
  input logic [LVL_W-1:0] fifo_level,
  input logic             quota_inc,
  input logic             quota_full,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [CNT_W-1:0] rsp_count
);
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> (fifo_level < LVL_W'(NUM_IDS)));

  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> (fifo_level != '0));

  assert_quota_cap_R5: assert property (@(posedge clk) disable iff (rst)
    quota_inc |-> !quota_full);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_err_in_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_count <= CNT_W'(MAX_OPS)));
endmodule

bind eid_alloc_mgr eid_alloc_mgr_chk #(
  .NUM_IDS(NUM_IDS), .MAX_OPS(MAX_OPS), .LVL_W(LVL_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst),
  .fifo_push(fifo_push), .fifo_pop(fifo_pop), .fifo_level(fifo_level),
  .quota_inc(quota_inc), .quota_full(quota_full),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_count(rsp_count)
);

// File: tb/eid_alloc_mgr_bench.sv
`timescale 1ns/1ps
module eid_alloc_mgr_bench;
  localparam int NUM_BU  = 4;
  localparam int NUM_IDS = 32;
  localparam int MAX_OPS = 16;
  localparam int LIMIT   = 12;
  localparam int ID_W    = 5;
  localparam int BU_W    = 2;
  localparam int CNT_W   = 5;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    req_valid = 1'b0;
  logic                    req_ready;
  logic                    req_op = 1'b0;
  logic [BU_W-1:0]         req_bu = '0;
  logic [CNT_W-1:0]        req_count = '0;
  logic [MAX_OPS*ID_W-1:0] req_ids = '0;
  logic                    rsp_valid;
  logic [CNT_W-1:0]        rsp_count;
  logic [MAX_OPS*ID_W-1:0] rsp_ids;
  logic                    rsp_err;

  always #2.5 clk = ~clk;

  eid_alloc_mgr #(.NUM_BU(NUM_BU), .NUM_IDS(NUM_IDS), .MAX_OPS(MAX_OPS), .LIMIT(LIMIT))
  u_eid_alloc_mgr (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_bu(req_bu), .req_count(req_count), .req_ids(req_ids),
    .rsp_valid(rsp_valid), .rsp_count(rsp_count), .rsp_ids(rsp_ids), .rsp_err(rsp_err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference model state
  int free_q[$];
  int owner_m[NUM_IDS];
  int outst_m[NUM_BU];

  // scoreboard
  int                      sb_cnt[$];
  logic [MAX_OPS*ID_W-1:0] sb_ids[$];
  bit                      sb_err[$];
  string                   sb_tag[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  // monitor: pop expected item on every response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb_cnt.size() == 0) begin
        check(1'b0, "R9 unexpected response", 1, 0);
      end else begin
        int ec; logic [MAX_OPS*ID_W-1:0] ei; bit ee; string et;
        ec = sb_cnt.pop_front(); ei = sb_ids.pop_front();
        ee = sb_err.pop_front(); et = sb_tag.pop_front();
        check(int'(rsp_count) == ec, {et, " count"}, int'(rsp_count), ec);
        for (int i = 0; i < MAX_OPS; i++)
          if (rsp_ids[i*ID_W +: ID_W] !== ei[i*ID_W +: ID_W])
            check(1'b0, {et, " id slot"}, int'(rsp_ids[i*ID_W +: ID_W]), int'(ei[i*ID_W +: ID_W]));
        check(rsp_err == ee, {et, " err"}, int'(rsp_err), int'(ee));
      end
    end
  end

  task automatic issue(input bit op, input int bu, input int cnt, input logic [MAX_OPS*ID_W-1:0] ids);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bu = BU_W'(bu);
    req_count = CNT_W'(cnt); req_ids = ids;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b0, "R9 ready low after accept", int'(req_ready), 0);
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 one-cycle pulse", int'(rsp_valid), 0);
  endtask

  task automatic do_alloc(input int bu, input int cnt, input string tag);
    int n, k; logic [MAX_OPS*ID_W-1:0] e;
    n = (cnt > MAX_OPS) ? MAX_OPS : cnt; k = 0; e = '0;
    for (int i = 0; i < n; i++) begin
      int id;
      if (free_q.size() == 0 || outst_m[bu] >= LIMIT) break;
      id = free_q.pop_front();
      owner_m[id] = bu; outst_m[bu]++;
      e[k*ID_W +: ID_W] = ID_W'(id); k++;
    end
    sb_cnt.push_back(k); sb_ids.push_back(e); sb_err.push_back(1'b0); sb_tag.push_back(tag);
    issue(1'b0, bu, cnt, '0);
  endtask

  task automatic do_clear(input int bu, input int q[$], input string tag);
    int k; bit er; logic [MAX_OPS*ID_W-1:0] v;
    k = 0; er = 0; v = '0;
    for (int i = 0; i < q.size(); i++) begin
      v[i*ID_W +: ID_W] = ID_W'(q[i]);
      if (owner_m[q[i]] == bu) begin
        owner_m[q[i]] = -1; outst_m[bu]--; free_q.push_back(q[i]); k++;
      end else er = 1;
    end
    sb_cnt.push_back(k); sb_ids.push_back('0); sb_err.push_back(er); sb_tag.push_back(tag);
    issue(1'b1, bu, q.size(), v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      finish_up();
    end
  end

  initial begin
    int cyc;
    int q[$];
    for (int i = 0; i < NUM_IDS; i++) begin free_q.push_back(i); owner_m[i] = -1; end
    for (int b = 0; b < NUM_BU; b++) outst_m[b] = 0;

    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid in reset", int'(rsp_valid), 0);
    check(req_ready == 1'b0, "R1 ready in reset", int'(req_ready), 0);
    rst = 1'b0;
    cyc = 0;
    while (!req_ready && cyc < 100) begin @(negedge clk); cyc++; end
    check(cyc == NUM_IDS, "R1 fill cycles", cyc, NUM_IDS);

    do_alloc(0, 4,  "R1 R2 first ids ascending");
    do_alloc(1, 20, "R5 R8 clamp and cap");
    do_alloc(1, 1,  "R5 at cap grants 0");
    q = '{2, 0};   do_clear(0, q, "R6 owner clears");
    q = '{1};      do_clear(2, q, "R7 foreign id");
    q = '{31};     do_clear(2, q, "R7 free id");
    do_alloc(2, 12, "R3 reuse after older frees");
    do_alloc(3, 10, "R3 R4 partial grant");
    do_alloc(3, 3,  "R4 empty pool");
    do_alloc(0, 0,  "R8 zero alloc");
    q = {};        do_clear(0, q, "R8 zero clear");
    q = '{1, 3, 1}; do_clear(0, q, "R7 duplicate entry");
    q = '{4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15};
    do_clear(1, q, "R6 bulk release");
    do_alloc(3, 5,  "R3 release order");
    q = '{1};      do_clear(0, q, "R7 id now held by other builder");
    q = '{1};      do_clear(3, q, "R6 R7 foreign clear left owner intact");

    repeat (4) @(negedge clk);
    check(sb_cnt.size() == 0, "R9 responses outstanding", sb_cnt.size(), 0);
    finish_up();
  end
endmodule